// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block sits between two 8-bit buses, A and B. It holds one storage latch for each direction of flow. A word arriving on A can be captured and presented on B, and a word arriving on B can be captured and presented on A. Each direction has three active-low controls: a chip enable, a latch enable and an output enable. The chip enable qualifies both the capture path and the drive path, so each latch and each output stage is steered on its own.

The latches are clocked equivalents of level-sensitive latches. While a latch is open, its data input flows straight through to the output stage in the same cycle. The stored copy is refreshed at every rising clock edge on which the latch is open. When the latch closes, it keeps the word that was sampled at the last such edge.

A port is not modelled as a tri-state pin. Each port has an input bus, an output bus and a single drive-enable flag that covers all of its bits. The two directions never arbitrate against each other: if both output stages are enabled, both ports drive at the same time, and keeping the external bus free of contention is up to the system.

Top module: `bus_xcvr`

## Requirements
- R1: While rst_ni is low, and after it rises, both stored words are zero, both drive-enable flags are 0 and both output buses read zero, until the controls open a path.
- R2: While ab_ce_ni and ab_le_ni are both 0, the A-to-B latch is open. Its content equals a_i in the same cycle, and it is stored at every rising clk_i edge.
- R3: When ab_le_ni is 1 and ab_ce_ni is 0, the A-to-B latch holds the a_i value sampled at the last rising edge on which it was open. Later changes on a_i have no effect.
- R4: While ab_ce_ni is 1, the A-to-B latch holds its value and b_oe_o is 0, whatever ab_le_ni and ab_oe_ni do.
- R5: b_oe_o is 1 exactly when ab_ce_ni and ab_oe_ni are both 0. While it is 1, b_o equals the A-to-B latch content, which is a_i when the latch is open.
- R6: When a port's drive-enable flag is 0, that port's output bus is all zeros, standing in for high impedance.
- R7: The B-to-A direction follows R2 to R5 with ba_ce_ni, ba_le_ni and ba_oe_ni, taking b_i into its latch and driving a_o and a_oe_o.
- R8: The two directions are independent. Opening, closing or driving one of them never changes the other's latch or output, and both ports may drive at the same time.
- R9: An output enable has no effect on its latch. Toggling it with the latch closed leaves the stored word unchanged when it is next driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; stored words update on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 8 | Data received from port A |
| a_o | output | 8 | Data driven onto port A (zero when undriven) |
| a_oe_o | output | 1 | Port A drive enable |
| b_i | input | 8 | Data received from port B |
| b_o | output | 8 | Data driven onto port B (zero when undriven) |
| b_oe_o | output | 1 | Port B drive enable |
| ab_ce_ni | input | 1 | A-to-B chip enable, active low |
| ab_le_ni | input | 1 | A-to-B latch enable, active low |
| ab_oe_ni | input | 1 | A-to-B output enable, active low |
| ba_ce_ni | input | 1 | B-to-A chip enable, active low |
| ba_le_ni | input | 1 | B-to-A latch enable, active low |
| ba_oe_ni | input | 1 | B-to-A output enable, active low |

## Verification
Directed sequences cover the distinct cases. A transparent flow-through with A changing every cycle shows whether the output follows the input in the same cycle or lags a cycle behind. A close of the latch on the same cycle that A changes shows whether the captured word comes from the last open edge or from the closing cycle. A chip-enable-high phase, with the latch enable and output enable toggling underneath it, shows whether the chip enable really gates both paths. Output-enable toggling with the latch closed, and both directions driving at once, separate the output path from storage and keep each direction apart from the other. A long seeded random run then mixes all six controls and both data buses, so that combinations no directed case names are also checked against the bench's model.

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;
  localparam int unsigned NUM_DIR = 2;

  typedef enum logic [0:0] {
    DIR_AB = 1'b0,
    DIR_BA = 1'b1
  } dir_e;

  typedef struct packed {
    logic ce_n;
    logic le_n;
    logic oe_n;
  } dir_ctrl_t;

  function automatic logic path_open(input logic ce_n, input logic gate_n);
    return ~ce_n & ~gate_n;
  endfunction
endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ce_ni,
  input  logic         le_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] held_o
);
  import bus_xcvr_pkg::*;

  logic         open_w;
  logic [W-1:0] held_q;

  assign open_w = path_open(ce_ni, le_ni);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     held_q <= '0;
    else if (open_w) held_q <= d_i;
  end

  // open latch is transparent within the cycle
  assign q_o    = open_w ? d_i : held_q;
  assign held_o = held_q;
endmodule

// File: rtl/xcvr_drive.sv
module xcvr_drive #(
  parameter int unsigned W = 8
) (
  input  logic         ce_ni,
  input  logic         oe_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic         oe_o
);
  import bus_xcvr_pkg::*;

  assign oe_o = path_open(ce_ni, oe_ni);
  assign q_o  = oe_o ? d_i : '0;
endmodule

// File: rtl/bus_xcvr.sv
module bus_xcvr #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  output logic [W-1:0] a_o,
  output logic         a_oe_o,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] b_o,
  output logic         b_oe_o,
  input  logic         ab_ce_ni,
  input  logic         ab_le_ni,
  input  logic         ab_oe_ni,
  input  logic         ba_ce_ni,
  input  logic         ba_le_ni,
  input  logic         ba_oe_ni
);
  import bus_xcvr_pkg::*;

  dir_ctrl_t    ctrl   [NUM_DIR];
  logic [W-1:0] src    [NUM_DIR];
  logic [W-1:0] lat_q  [NUM_DIR];
  logic [W-1:0] held_q [NUM_DIR];
  logic [W-1:0] drv_q  [NUM_DIR];
  logic         drv_oe [NUM_DIR];

  assign ctrl[DIR_AB] = '{ce_n: ab_ce_ni, le_n: ab_le_ni, oe_n: ab_oe_ni};
  assign ctrl[DIR_BA] = '{ce_n: ba_ce_ni, le_n: ba_le_ni, oe_n: ba_oe_ni};
  assign src[DIR_AB]  = a_i;
  assign src[DIR_BA]  = b_i;

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    xcvr_store #(.W(W)) u_store (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ce_ni  (ctrl[d].ce_n),
      .le_ni  (ctrl[d].le_n),
      .d_i    (src[d]),
      .q_o    (lat_q[d]),
      .held_o (held_q[d])
    );

    xcvr_drive #(.W(W)) u_drive (
      .ce_ni (ctrl[d].ce_n),
      .oe_ni (ctrl[d].oe_n),
      .d_i   (lat_q[d]),
      .q_o   (drv_q[d]),
      .oe_o  (drv_oe[d])
    );
  end

  // A-to-B drives port B, B-to-A drives port A
  assign b_o    = drv_q[DIR_AB];
  assign b_oe_o = drv_oe[DIR_AB];
  assign a_o    = drv_q[DIR_BA];
  assign a_oe_o = drv_oe[DIR_BA];
endmodule

// File: rtl/bus_xcvr_checker.sv
module bus_xcvr_checker #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] a_i,
  input logic [W-1:0] a_o,
  input logic         a_oe_o,
  input logic [W-1:0] b_i,
  input logic [W-1:0] b_o,
  input logic         b_oe_o,
  input logic         ab_ce_ni,
  input logic         ab_le_ni,
  input logic         ba_ce_ni,
  input logic         ba_le_ni,
  input logic [W-1:0] ab_held_i,
  input logic [W-1:0] ba_held_i
);
  assert_ab_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ab_ce_ni && !ab_le_ni) |=> ab_held_i == $past(a_i));
  assert_ab_le_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ab_le_ni |=> $stable(ab_held_i));
  assert_ab_ce_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ab_ce_ni |=> $stable(ab_held_i));
  assert_ab_ce_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ab_ce_ni |-> !b_oe_o);
  assert_ab_drive_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_oe_o && ab_le_ni) |-> b_o == ab_held_i);
  assert_ab_drive_flow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_oe_o && !ab_le_ni) |-> b_o == a_i);
  assert_b_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !b_oe_o |-> b_o == '0);
  assert_a_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !a_oe_o |-> a_o == '0);
  assert_ba_capture_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ba_ce_ni && !ba_le_ni) |=> ba_held_i == $past(b_i));
  assert_ba_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ba_ce_ni || ba_le_ni) |=> $stable(ba_held_i));
  assert_ba_ce_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ba_ce_ni |-> !a_oe_o);
  assert_ba_drive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_oe_o && ba_le_ni) |-> a_o == ba_held_i);
endmodule

bind bus_xcvr bus_xcvr_checker #(.W(W)) u_bus_xcvr_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .a_i       (a_i),
  .a_o       (a_o),
  .a_oe_o    (a_oe_o),
  .b_i       (b_i),
  .b_o       (b_o),
  .b_oe_o    (b_oe_o),
  .ab_ce_ni  (ab_ce_ni),
  .ab_le_ni  (ab_le_ni),
  .ba_ce_ni  (ba_ce_ni),
  .ba_le_ni  (ba_le_ni),
  .ab_held_i (held_q[0]),
  .ba_held_i (held_q[1])
);

// File: tb/bus_xcvr_bench.sv
`timescale 1ns/1ps
module bus_xcvr_bench;
  localparam int unsigned W = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic [W-1:0] a_o, b_o;
  logic         a_oe_o, b_oe_o;
  logic ab_ce_ni = 1'b1, ab_le_ni = 1'b1, ab_oe_ni = 1'b1;
  logic ba_ce_ni = 1'b1, ba_le_ni = 1'b1, ba_oe_ni = 1'b1;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [W-1:0] m_ab = '0, m_ba = '0;

  always #2.5 clk_i = ~clk_i;

  bus_xcvr #(.W(W)) u_bus_xcvr (.*);

  function automatic logic [W-1:0] exp_lat(logic ce, logic le, logic [W-1:0] d, logic [W-1:0] h);
    return (!ce && !le) ? d : h;
  endfunction

  function automatic logic exp_oe(logic ce, logic oe);
    return !ce && !oe;
  endfunction

  task automatic chk(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive after negedge, check mid-cycle, advance model at posedge
  task automatic step(logic [W-1:0] a, logic [W-1:0] b,
                      logic ace, logic ale, logic aoe,
                      logic bce, logic ble, logic boe, string req_b, string req_a);
    logic eb, ea;
    @(negedge clk_i);
    a_i = a; b_i = b;
    ab_ce_ni = ace; ab_le_ni = ale; ab_oe_ni = aoe;
    ba_ce_ni = bce; ba_le_ni = ble; ba_oe_ni = boe;
    #1;
    eb = exp_oe(ace, aoe);
    ea = exp_oe(bce, boe);
    chk(req_b, "b_oe_o", W'(b_oe_o), W'(eb));
    chk(req_b, "b_o", b_o, eb ? exp_lat(ace, ale, a, m_ab) : '0);
    chk(req_a, "a_oe_o", W'(a_oe_o), W'(ea));
    chk(req_a, "a_o", a_o, ea ? exp_lat(bce, ble, b, m_ba) : '0);
    @(posedge clk_i);
    if (!ace && !ale) m_ab = a;
    if (!bce && !ble) m_ba = b;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk_i);
    #1;
    // R1: reset state
    chk("R1", "b_oe_o", W'(b_oe_o), '0);
    chk("R1", "a_oe_o", W'(a_oe_o), '0);
    chk("R1", "b_o", b_o, '0);
    chk("R1", "a_o", a_o, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: stored zero seen once driven with latches closed
    step(8'h5a, 8'ha5, 0, 1, 0, 0, 1, 0, "R1", "R1");
    // R2: flow-through with A changing every cycle
    for (int i = 0; i < 6; i++)
      step(W'(8'h11 * (i + 1)), 8'h00, 0, 0, 0, 1, 1, 1, "R2", "R6");
    // R3: close on the cycle A changes; last open edge wins
    step(8'hc3, 8'h00, 0, 0, 0, 1, 1, 1, "R2", "R6");
    step(8'h3c, 8'h00, 0, 1, 0, 1, 1, 1, "R3", "R6");
    for (int i = 0; i < 4; i++)
      step(W'($urandom), 8'h00, 0, 1, 0, 1, 1, 1, "R3", "R6");
    // R4: ce high gates both paths
    for (int i = 0; i < 6; i++)
      step(W'($urandom), 8'h00, 1, W'(i) & 1'b1, 1'b0, 1, 1, 1, "R4", "R6");
    step(8'h00, 8'h00, 0, 1, 0, 1, 1, 1, "R4", "R6");
    // R9: oe toggling with latch closed
    for (int i = 0; i < 4; i++)
      step(W'($urandom), 8'h00, 0, 1, W'(i) & 1'b1, 1, 1, 1, "R9", "R6");
    // R7: B-to-A capture and drive
    step(8'h00, 8'h7e, 1, 1, 1, 0, 0, 0, "R6", "R7");
    step(8'h00, 8'h81, 1, 1, 1, 0, 1, 0, "R7", "R7");
    step(8'h00, 8'hff, 1, 1, 1, 0, 1, 0, "R6", "R7");
    // R8: both directions drive together, independently
    step(8'h99, 8'h66, 0, 0, 0, 0, 0, 0, "R8", "R8");
    step(8'h12, 8'h34, 0, 1, 0, 0, 1, 0, "R8", "R8");
    step(8'h00, 8'h00, 0, 1, 0, 1, 0, 0, "R8", "R8");
    // random mix: R5, R7
    for (int i = 0; i < 600; i++)
      step(W'($urandom), W'($urandom),
           1'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), 1'($urandom), "R5", "R7");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule